// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits between one processor thread and the interrupt source controller. It keeps the processor's current priority, a request register for inter-processor interrupts (IPIs), and at most one pending interrupt with its latched priority. It raises the processor's interrupt line whenever an interrupt is pending. The source controller offers a source number together with a priority. The presenter takes the offer only when the offer is more favored than both the processor priority and any interrupt already pending. In every other case it sends the number back as a reject. The IPI channel uses the fixed source number 2 and competes with offered sources by priority. An IPI is never rejected back to the source controller.

Software drives a single command port. Set-priority and set-IPI take an 8-bit value. Accept takes the pending interrupt and returns the packed word. End-of-interrupt writes a full word: it restores the priority and names the source that is being completed. When the processor lowers its priority and nothing is pending, the presenter asks the source controller to resend any interrupts that were held back. Every state change and every message to the source controller is registered, so each one is seen one clock after the cycle that causes it.

Top module: `irq_presenter`

## Requirements
- R1: After a synchronous active-high reset, `acc_word` is 0, the latched pending priority and the IPI request are 0xFF, `cpu_irq` is low, and `rej_valid`, `eoi_valid` and `resend_req` are low.
- R2: `acc_word` holds the processor priority in bits 31:24 and the pending source number in bits 23:0, and it is valid in the cycle an accept is issued. An accept has `cmd_op` = 2. One cycle after the accept, the priority field holds the former pending priority, the source field is 0, the pending priority is 0xFF and `cpu_irq` is low.
- R3: An offer is presented when it comes in a cycle with no command, its priority is numerically below the processor priority, and either nothing is pending or its priority is numerically below the pending priority. One cycle later the source field holds the offered number and `cpu_irq` is high. If a non-IPI source is displaced, that source is rejected in the same cycle.
- R4: An offer that is not presented is rejected: one cycle later `rej_valid` is high with `rej_num` equal to the offered number, and the pending word is unchanged.
- R5: Set-IPI (`cmd_op` = 1, value in `cmd_data[7:0]`) stores the value. If the value is below the processor priority, and nothing is pending or the pending priority is numerically above the value, the IPI is presented as source 2 with that priority. A displaced non-IPI source is rejected.
- R6: Set-priority (`cmd_op` = 0, value in `cmd_data[7:0]`) always stores the value. If the value is below the old priority and an interrupt is pending whose priority is equal to or above the value, the pending interrupt is cleared and `cpu_irq` drops. The cleared source is rejected unless it is the IPI.
- R7: If the set-priority value is equal to or above the old priority and nothing is pending, `resend_req` pulses once. The IPI is then presented if the stored IPI request is below the new priority.
- R8: End-of-interrupt (`cmd_op` = 3) replaces only bits 31:24 with `cmd_data[31:24]` and pulses `eoi_valid` with `eoi_num` equal to `cmd_data[23:0]`. The IPI is then presented under the rule of R5, compared against the new priority.
- R9: An offer in a cycle that carries a command is ignored: it is neither presented nor rejected.
- R10: `cpu_irq` is high exactly when the source field of `acc_word` is nonzero.
- R11: The IPI source number never appears on `rej_num` with `rej_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 set-priority, 1 set-IPI, 2 accept, 3 end-of-interrupt |
| cmd_data | input | 32 | Command operand |
| acc_word | output | 32 | Packed priority and pending source; the accept return value |
| src_valid | input | 1 | Source controller offers an interrupt |
| src_num | input | 24 | Offered source number (0 and 2 reserved) |
| src_prio | input | 8 | Offered priority |
| rej_valid | output | 1 | Reject pulse to the source controller |
| rej_num | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt pulse to the source controller |
| eoi_num | output | 24 | Completed source number |
| resend_req | output | 1 | Request that the source controller resend held interrupts |
| cpu_irq | output | 1 | Interrupt line to the processor |

## Verification
The hardest cases to reach are the ones where a pending IPI and offered sources displace each other. An IPI that gets displaced must disappear without a reject, and it must come back only through a later priority drop or an end-of-interrupt. A directed prologue builds that chain step by step: present a source, displace it with the IPI, raise the priority over the IPI, then lower the priority so the IPI comes back. A long seeded random run follows, with offers drawn from a small pool of numbers and priorities so that equal-priority ties and offers that collide with commands happen often.

// File: rtl/ipres_pkg.sv
package ipres_pkg;
    localparam int PRIO_W = 8;
    localparam int SRC_W  = 24;
    localparam int WORD_W = PRIO_W + SRC_W;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [SRC_W-1:0]  srcnum_t;

    localparam prio_t   PRIO_IDLE       = '1;
    localparam srcnum_t SRC_NONE        = '0;
    localparam srcnum_t IPI_SRC_DEFAULT = srcnum_t'(2);

    typedef enum logic [1:0] {
        OP_SET_PRIO = 2'd0,
        OP_SET_IPI  = 2'd1,
        OP_ACCEPT   = 2'd2,
        OP_EOI      = 2'd3
    } cmd_op_e;

    typedef struct packed {
        prio_t   cur_prio;
        srcnum_t src;
        prio_t   pend_prio;
        prio_t   ipi_req;
    } pres_state_t;

    typedef struct packed {
        logic    valid;
        srcnum_t num;
    } src_msg_t;

    localparam pres_state_t RESET_STATE = '{cur_prio: '0, src: '0,
                                            pend_prio: '1, ipi_req: '1};

    // Lower value wins.
    function automatic logic beats(prio_t a, prio_t b);
        return a < b;
    endfunction
endpackage

// File: rtl/ipres_step.sv
module ipres_step
    import ipres_pkg::*;
#(
    parameter srcnum_t IPI_SOURCE = IPI_SRC_DEFAULT
) (
    input  pres_state_t       cur,
    input  logic              cmd_valid,
    input  cmd_op_e           cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic              offer_valid,
    input  srcnum_t           offer_num,
    input  prio_t             offer_prio,
    output pres_state_t       nxt,
    output src_msg_t          rej,
    output src_msg_t          eoi,
    output logic              resend,
    output logic              ipi_eval
);
    prio_t req_prio;
    logic  busy;

    assign req_prio = cmd_data[PRIO_W-1:0];
    assign busy     = (cur.src != SRC_NONE);

    always_comb begin
        nxt      = cur;
        rej      = '0;
        eoi      = '0;
        resend   = 1'b0;
        ipi_eval = 1'b0;
        if (cmd_valid) begin
            unique case (cmd_op)
                OP_SET_PRIO: begin
                    nxt.cur_prio = req_prio;
                    if (beats(req_prio, cur.cur_prio)) begin
                        // Raising priority: drop a pending one that no longer wins.
                        if (busy && !beats(cur.pend_prio, req_prio)) begin
                            nxt.src       = SRC_NONE;
                            nxt.pend_prio = PRIO_IDLE;
                            if (cur.src != IPI_SOURCE) begin
                                rej.valid = 1'b1;
                                rej.num   = cur.src;
                            end
                        end
                    end else if (!busy) begin
                        resend   = 1'b1;
                        ipi_eval = 1'b1;
                    end
                end
                OP_SET_IPI: begin
                    nxt.ipi_req = req_prio;
                    ipi_eval    = 1'b1;
                end
                OP_ACCEPT: begin
                    nxt.cur_prio  = cur.pend_prio;
                    nxt.src       = SRC_NONE;
                    nxt.pend_prio = PRIO_IDLE;
                end
                OP_EOI: begin
                    nxt.cur_prio = cmd_data[WORD_W-1:SRC_W];
                    eoi.valid    = 1'b1;
                    eoi.num      = cmd_data[SRC_W-1:0];
                    ipi_eval     = 1'b1;
                end
                default: ;
            endcase
        end else if (offer_valid) begin
            if (beats(offer_prio, cur.cur_prio) &&
                (!busy || beats(offer_prio, cur.pend_prio))) begin
                if (busy && cur.src != IPI_SOURCE) begin
                    rej.valid = 1'b1;
                    rej.num   = cur.src;
                end
                nxt.src       = offer_num;
                nxt.pend_prio = offer_prio;
            end else begin
                rej.valid = 1'b1;
                rej.num   = offer_num;
            end
        end
    end
endmodule

// File: rtl/ipres_ipi_check.sv
module ipres_ipi_check
    import ipres_pkg::*;
#(
    parameter srcnum_t IPI_SOURCE = IPI_SRC_DEFAULT
) (
    input  pres_state_t st_in,
    input  logic        eval,
    output pres_state_t st_out,
    output src_msg_t    rej
);
    logic wants;
    logic wins;

    assign wants = eval && beats(st_in.ipi_req, st_in.cur_prio);
    assign wins  = (st_in.src == SRC_NONE) || beats(st_in.ipi_req, st_in.pend_prio);

    always_comb begin
        st_out = st_in;
        rej    = '0;
        if (wants && wins) begin
            if (st_in.src != SRC_NONE && st_in.src != IPI_SOURCE) begin
                rej.valid = 1'b1;
                rej.num   = st_in.src;
            end
            st_out.src       = IPI_SOURCE;
            st_out.pend_prio = st_in.ipi_req;
        end
    end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
    import ipres_pkg::*;
#(
    parameter srcnum_t IPI_SOURCE = IPI_SRC_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    output logic [WORD_W-1:0] acc_word,
    input  logic              src_valid,
    input  logic [SRC_W-1:0]  src_num,
    input  logic [PRIO_W-1:0] src_prio,
    output logic              rej_valid,
    output logic [SRC_W-1:0]  rej_num,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_num,
    output logic              resend_req,
    output logic              cpu_irq
);
    pres_state_t state_q, st_step, st_final;
    src_msg_t    rej_step, rej_ipi, rej_q, eoi_step, eoi_q;
    logic        resend_step, ipi_eval, resend_q, irq_q;
    cmd_op_e     op;

    assign op = cmd_op_e'(cmd_op);

    ipres_step #(.IPI_SOURCE(IPI_SOURCE)) u_step (
        .cur(state_q), .cmd_valid(cmd_valid), .cmd_op(op), .cmd_data(cmd_data),
        .offer_valid(src_valid), .offer_num(src_num), .offer_prio(src_prio),
        .nxt(st_step), .rej(rej_step), .eoi(eoi_step),
        .resend(resend_step), .ipi_eval(ipi_eval)
    );

    ipres_ipi_check #(.IPI_SOURCE(IPI_SOURCE)) u_ipi (
        .st_in(st_step), .eval(ipi_eval), .st_out(st_final), .rej(rej_ipi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= RESET_STATE;
            rej_q    <= '0;
            eoi_q    <= '0;
            resend_q <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            state_q  <= st_final;
            rej_q    <= rej_step.valid ? rej_step : rej_ipi;
            eoi_q    <= eoi_step;
            resend_q <= resend_step;
            irq_q    <= (st_final.src != SRC_NONE);
        end
    end

    assign acc_word   = {state_q.cur_prio, state_q.src};
    assign rej_valid  = rej_q.valid;
    assign rej_num    = rej_q.num;
    assign eoi_valid  = eoi_q.valid;
    assign eoi_num    = eoi_q.num;
    assign resend_req = resend_q;
    assign cpu_irq    = irq_q;

    // The two reject producers never fire together (R3, R5).
    p_one_reject_r3: assert property (@(posedge clk) disable iff (rst)
        rej_step.valid |-> !rej_ipi.valid);

    p_accept_takes_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == OP_ACCEPT) |=>
            (acc_word == {$past(state_q.pend_prio), SRC_NONE}) && !cpu_irq);

    p_offer_present_r3: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid && src_valid && beats(src_prio, state_q.cur_prio) &&
         (state_q.src == SRC_NONE || beats(src_prio, state_q.pend_prio)))
            |=> (acc_word[SRC_W-1:0] == $past(src_num)) && cpu_irq);

    p_eoi_field_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == OP_EOI) |=>
            eoi_valid && (eoi_num == $past(cmd_data[SRC_W-1:0])) &&
            (acc_word[WORD_W-1:SRC_W] == $past(cmd_data[WORD_W-1:SRC_W])));

    p_raise_drops_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == OP_SET_PRIO && state_q.src != SRC_NONE &&
         beats(cmd_data[PRIO_W-1:0], state_q.cur_prio) &&
         !beats(state_q.pend_prio, cmd_data[PRIO_W-1:0])) |=> !cpu_irq);

    p_no_ipi_reject_r11: assert property (@(posedge clk) disable iff (rst)
        rej_valid |-> (rej_num != IPI_SOURCE));

    p_line_tracks_r10: assert property (@(posedge clk) disable iff (rst)
        cpu_irq == (acc_word[SRC_W-1:0] != SRC_NONE));
endmodule

// File: tb/tb_irq_presenter.sv
`timescale 1ns/1ps
module tb_irq_presenter;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [31:0] cmd_data;
    logic [31:0] acc_word;
    logic        src_valid;
    logic [23:0] src_num;
    logic [7:0]  src_prio;
    logic        rej_valid, eoi_valid, resend_req, cpu_irq;
    logic [23:0] rej_num, eoi_num;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // reference state
    logic [7:0]  m_cur, m_pp, m_mfrr;
    logic [23:0] m_src;
    logic        e_rej, e_eoi, e_res;
    logic [23:0] e_rejn, e_eoin;
    string       e_tag;

    localparam logic [23:0] IPI = 24'd2;

    always #2.5 clk = ~clk;

    irq_presenter dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .acc_word(acc_word), .src_valid(src_valid),
        .src_num(src_num), .src_prio(src_prio), .rej_valid(rej_valid),
        .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num),
        .resend_req(resend_req), .cpu_irq(cpu_irq)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic m_ipi();
        if (m_mfrr < m_cur && (m_src == 0 || m_mfrr < m_pp)) begin
            if (m_src != 0 && m_src != IPI) begin
                e_rej = 1; e_rejn = m_src;
            end
            m_src = IPI; m_pp = m_mfrr;
        end
    endtask

    task automatic model(bit cv, logic [1:0] op, logic [31:0] d,
                         bit sv, logic [23:0] sn, logic [7:0] sp);
        e_rej = 0; e_rejn = 0; e_eoi = 0; e_eoin = 0; e_res = 0; e_tag = "R9";
        if (cv) begin
            case (op)
                2'd0: begin
                    if (d[7:0] < m_cur) begin
                        e_tag = "R6";
                        if (m_src != 0 && d[7:0] <= m_pp) begin
                            if (m_src != IPI) begin e_rej = 1; e_rejn = m_src; end
                            m_src = 0; m_pp = 8'hFF;
                        end
                        m_cur = d[7:0];
                    end else begin
                        e_tag = "R7";
                        m_cur = d[7:0];
                        if (m_src == 0) begin e_res = 1; m_ipi(); end
                    end
                end
                2'd1: begin e_tag = "R5"; m_mfrr = d[7:0]; m_ipi(); end
                2'd2: begin e_tag = "R2"; m_cur = m_pp; m_src = 0; m_pp = 8'hFF; end
                default: begin
                    e_tag = "R8"; m_cur = d[31:24];
                    e_eoi = 1; e_eoin = d[23:0]; m_ipi();
                end
            endcase
        end else if (sv) begin
            if (sp < m_cur && (m_src == 0 || sp < m_pp)) begin
                e_tag = "R3";
                if (m_src != 0 && m_src != IPI) begin e_rej = 1; e_rejn = m_src; end
                m_src = sn; m_pp = sp;
            end else begin
                e_tag = "R4"; e_rej = 1; e_rejn = sn;
            end
        end
    endtask

    task automatic step(bit cv, logic [1:0] op, logic [31:0] d,
                        bit sv, logic [23:0] sn, logic [7:0] sp);
        cmd_valid = cv; cmd_op = op; cmd_data = d;
        src_valid = sv; src_num = sn; src_prio = sp;
        if (cv && op == 2'd2)
            check("R2", "accept word", acc_word, {m_cur, m_src});
        model(cv, op, d, sv, sn, sp);
        @(posedge clk);
        @(negedge clk);
        check(e_tag, "word", acc_word, {m_cur, m_src});
        check("R10", "irq line", {31'd0, cpu_irq}, {31'd0, m_src != 0});
        check({e_tag, "/R11"}, "reject", {7'd0, rej_valid, rej_num},
              {7'd0, e_rej, e_rejn});
        check(e_tag, "eoi", {7'd0, eoi_valid, eoi_num}, {7'd0, e_eoi, e_eoin});
        check(e_tag, "resend", {31'd0, resend_req}, {31'd0, e_res});
    endtask

    function automatic logic [7:0] pick_prio();
        case ($urandom_range(0, 7))
            0: return 8'h00; 1: return 8'h01; 2: return 8'h02; 3: return 8'h03;
            4: return 8'h05; 5: return 8'h08; 6: return 8'h10; default: return 8'hFF;
        endcase
    endfunction

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd2718);
        rst = 1; cmd_valid = 0; cmd_op = 0; cmd_data = 0;
        src_valid = 0; src_num = 0; src_prio = 0;
        m_cur = 0; m_src = 0; m_pp = 8'hFF; m_mfrr = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        check("R1", "word", acc_word, 32'h0);
        check("R1", "irq", {31'd0, cpu_irq}, 32'd0);
        check("R1", "pulses", {29'd0, rej_valid, eoi_valid, resend_req}, 32'd0);

        step(0, 0, 0, 1, 24'h5, 8'h03);               // R4: priority 0 blocks all
        step(1, 2'd2, 0, 0, 0, 0);                    // R1: accept shows pending prio 0xFF
        step(1, 2'd0, 32'h01, 0, 0, 0);               // R6 path, nothing pending
        step(1, 2'd0, 32'hFF, 0, 0, 0);               // R7: lower -> resend
        step(0, 0, 0, 1, 24'h5, 8'h04);               // R3: present
        step(0, 0, 0, 1, 24'h6, 8'h04);               // R4: tie rejected
        step(0, 0, 0, 1, 24'h7, 8'h02);               // R3: displace 5
        step(1, 2'd1, 32'hFF, 1, 24'h9, 8'h00);       // R9: offer ignored
        step(1, 2'd1, 32'h01, 0, 0, 0);               // R5: IPI displaces 7
        step(0, 0, 0, 1, 24'h8, 8'h01);               // R4: tie with IPI
        step(1, 2'd0, 32'h01, 0, 0, 0);               // R6/R11: IPI dropped silently
        step(1, 2'd0, 32'hFF, 0, 0, 0);               // R7: IPI re-presented
        step(1, 2'd2, 0, 0, 0, 0);                    // R2: accept IPI
        step(1, 2'd3, 32'hFF000002, 0, 0, 0);         // R8: EOI reopens IPI
        step(1, 2'd1, 32'hFF, 0, 0, 0);               // R5: request cleared
        step(1, 2'd2, 0, 0, 0, 0);                    // R2
        step(1, 2'd3, 32'hFF000010, 0, 0, 0);         // R8

        for (int i = 0; i < 4000; i++) begin
            bit          cv = ($urandom_range(0, 9) < 4);
            logic [1:0]  op = 2'($urandom_range(0, 3));
            logic [31:0] d;
            if (op == 2'd3)
                d = {pick_prio(), (($urandom_range(0, 1) == 1) ? m_src
                                   : 24'(16 + $urandom_range(0, 15)))};
            else
                d = {24'd0, pick_prio()};
            step(cv, op, d, ($urandom_range(0, 1) == 1),
                 24'(16 + $urandom_range(0, 15)), pick_prio());
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule